// File: doc/BRIEF.md
# Operand Selector Resolver

This block turns one 6-bit operand selector, taken from a 16-bit instruction word, into a concrete operand location for a 16-bit stack-oriented processor. The location can be a general register, a memory word, a slot on the downward-growing stack, one of the special registers (stack pointer, program counter, excess register), or a constant. The caller pulses `start` with the selector, a flag that says whether the selector came from the source (a) or the destination (b) field, and the current register file, stack pointer, program counter and excess register.

Some selectors need one extra word from the instruction stream. For those, the block raises a fetch request addressed at the current program counter and waits for the word on a valid/ready handshake. When the location is resolved, the block pulses `done` and holds the following until the next accepted request: the kind and index, the memory address, the direct value, the updated stack pointer and program counter, the extra cycle count and a write-enable.

The a operand is resolved before the b operand. The caller runs the block once for each field. The b field is only five bits wide.

Top module: `opnd_resolver`

## Requirements
- R1: Selectors 0x00..0x07 give kind 0 (register), with `op_idx` equal to the code and `op_value` equal to that register (A=0, B=1, C=2, X=3, Y=4, Z=5, I=6, J=7, register k at `regs[16k+15:16k]`), `wr_en`=1 and `extra_cycles`=0.
- R2: Selectors 0x08..0x0f give kind 1 (memory), with `op_addr` equal to the value of register (code & 7), `op_value`=0 and no extension fetch.
- R3: Selectors 0x10..0x17 give kind 1, with `op_addr` = register (code & 7) + extension word, modulo 2^16. They cost `extra_cycles`=1 and return `pc_out` = `pc_in`+1.
- R4: Selector 0x18 in the b position is a push: `op_addr` = SP−1 and `sp_out` = SP−1. In the a position it is a pop: `op_addr` = SP and `sp_out` = SP+1. Both wrap modulo 2^16.
- R5: Selector 0x19 gives kind 1 at `op_addr` = SP. Selector 0x1a gives kind 1 at SP + extension word, with `extra_cycles`=1.
- R6: Selectors 0x1b, 0x1c and 0x1d give kind 2 (special), with `op_idx` 0, 1 and 2 and `op_value` equal to SP, PC and EX respectively, `wr_en`=1 and no extension fetch.
- R7: Selector 0x1e gives kind 1 at `op_addr` = extension word. Selector 0x1f gives kind 3 (literal), with `op_value` = extension word and `wr_en`=0. Both have `extra_cycles`=1.
- R8: In the a position, selectors 0x20..0x3f give kind 3, with `op_value` = (code − 0x21) mod 2^16 and `wr_en`=0. So 0x20 gives 0xffff, 0x21 gives 0 and 0x3f gives 30.
- R9: In the b position, selector bit 5 is ignored: the low five bits alone pick the location, so b never yields a short literal.
- R10: An extension fetch drives `ext_valid`=1 with `ext_addr` = `pc_in` from the cycle after `start`. `ext_valid`, `ext_addr` and all result outputs hold until a cycle with `ext_ready`=1, which delivers `ext_data`. `done` follows one cycle after that cycle.
- R11: A selector without an extension word raises `done` one cycle after `start`. It leaves `pc_out` = `pc_in`, and `sp_out` = `sp_in` for every code other than 0x18.
- R12: `start` is ignored while `busy`=1, meaning while a fetch is pending. It produces no second result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a resolution this cycle |
| sel | input | 6 | Operand selector |
| is_a | input | 1 | 1 = source (a) field, 0 = destination (b) field |
| regs | input | 128 | Registers A..J, 16 bits each, A in the low bits |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter (address of next word) |
| ex_in | input | 16 | Current excess register |
| ext_valid | output | 1 | Extension word request |
| ext_addr | output | 16 | Address of the extension word |
| ext_ready | input | 1 | Extension word delivered this cycle |
| ext_data | input | 16 | Extension word |
| busy | output | 1 | Fetch pending, new requests ignored |
| done | output | 1 | One-cycle pulse: results updated |
| op_kind | output | 2 | 0 register, 1 memory, 2 special, 3 literal |
| op_idx | output | 3 | Register index, or special index (0 SP, 1 PC, 2 EX) |
| op_addr | output | 16 | Memory address for kind 1 |
| op_value | output | 16 | Direct value for kinds 0, 2, 3 (0 for kind 1) |
| sp_out | output | 16 | Stack pointer after the access |
| pc_out | output | 16 | Program counter after any extension fetch |
| extra_cycles | output | 2 | Extra cycles spent by the selector |
| wr_en | output | 1 | Writes to this operand allowed (0 for literals) |

## Verification
The timing of each result depends on whether the selector needs an extension word. A selector with no extension word has its results and `done` appear at the first clock edge after `start`. A selector with an extension word raises `ext_valid` at that edge and returns its results at the edge after the cycle in which `ext_ready` is high. The bench drives every input on the falling edge and samples on the next falling edge, so each check reads a value that has been settled for half a period. For fetches it also samples the held outputs in the wait cycles before `ext_ready` is raised, and it samples once more after a result to confirm that `done` has dropped.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [1:0] {
    OK_REG  = 2'd0,
    OK_MEM  = 2'd1,
    OK_SPEC = 2'd2,
    OK_LIT  = 2'd3
  } opk_e;

  localparam logic [2:0] SPX_SP = 3'd0;
  localparam logic [2:0] SPX_PC = 3'd1;
  localparam logic [2:0] SPX_EX = 3'd2;

  localparam logic [2:0] LO_STACK = 3'd0;
  localparam logic [2:0] LO_PEEK  = 3'd1;
  localparam logic [2:0] LO_PICK  = 3'd2;
  localparam logic [2:0] LO_SP    = 3'd3;
  localparam logic [2:0] LO_PC    = 3'd4;
  localparam logic [2:0] LO_EX    = 3'd5;
  localparam logic [2:0] LO_ABS   = 3'd6;
  localparam logic [2:0] LO_IMM   = 3'd7;

endpackage

// File: rtl/opr_classify.sv
module opr_classify
  import opr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int SW   = 6
) (
  input  logic [SW-1:0]          sel,
  input  logic                   is_a,
  input  logic [NREG*DW-1:0]     regs,
  input  logic [DW-1:0]          sp_in,
  input  logic [DW-1:0]          pc_in,
  input  logic [DW-1:0]          ex_in,
  output opk_e                   kind,
  output logic [$clog2(NREG)-1:0] idx,
  output logic                   need_ext,
  output logic                   ext_is_val,
  output logic [DW-1:0]          base,
  output logic [DW-1:0]          value,
  output logic [DW-1:0]          sp_new
);
  localparam int IW = $clog2(NREG);

  logic [SW-1:0] code;
  logic [IW-1:0] ridx;
  logic [DW-1:0] rval;

  always_comb begin
    // b field is five bits wide: force the top bit clear
    code = is_a ? sel : {1'b0, sel[SW-2:0]};
    ridx = code[IW-1:0];
    rval = regs[ridx*DW +: DW];

    kind       = OK_REG;
    idx        = ridx;
    need_ext   = 1'b0;
    ext_is_val = 1'b0;
    base       = '0;
    value      = '0;
    sp_new     = sp_in;

    if (code[SW-1]) begin
      kind  = OK_LIT;
      idx   = '0;
      value = DW'(code[SW-2:0]) - DW'(1);
    end else begin
      unique case (code[4:3])
        2'd0: value = rval;
        2'd1: begin kind = OK_MEM; base = rval; end
        2'd2: begin kind = OK_MEM; base = rval; need_ext = 1'b1; end
        default: begin
          idx = '0;
          unique case (code[2:0])
            LO_STACK: begin
              kind = OK_MEM;
              if (is_a) begin
                base   = sp_in;
                sp_new = sp_in + DW'(1);
              end else begin
                base   = sp_in - DW'(1);
                sp_new = sp_in - DW'(1);
              end
            end
            LO_PEEK: begin kind = OK_MEM; base = sp_in; end
            LO_PICK: begin kind = OK_MEM; base = sp_in; need_ext = 1'b1; end
            LO_SP:   begin kind = OK_SPEC; idx = IW'(SPX_SP); value = sp_in; end
            LO_PC:   begin kind = OK_SPEC; idx = IW'(SPX_PC); value = pc_in; end
            LO_EX:   begin kind = OK_SPEC; idx = IW'(SPX_EX); value = ex_in; end
            LO_ABS:  begin kind = OK_MEM; need_ext = 1'b1; end
            default: begin kind = OK_LIT; need_ext = 1'b1; ext_is_val = 1'b1; end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/opr_extfetch.sv
module opr_extfetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] pc_in,
  input  logic          ext_ready,
  output logic          ext_valid,
  output logic [AW-1:0] ext_addr,
  output logic          fire
);
  typedef enum logic {EF_IDLE, EF_WAIT} ef_e;

  ef_e           st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign ext_valid = (st_q == EF_WAIT);
  assign ext_addr  = addr_q;
  assign fire      = ext_valid & ext_ready;

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    addr_d  = pc_in;
    unique case (st_q)
      EF_IDLE: if (launch) begin st_d = EF_WAIT; addr_en = 1'b1; end
      default: if (ext_ready) st_d = EF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EF_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int SW   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SW-1:0]           sel,
  input  logic                    is_a,
  input  logic [NREG*DW-1:0]      regs,
  input  logic [DW-1:0]           sp_in,
  input  logic [DW-1:0]           pc_in,
  input  logic [DW-1:0]           ex_in,
  output logic                    ext_valid,
  output logic [DW-1:0]           ext_addr,
  input  logic                    ext_ready,
  input  logic [DW-1:0]           ext_data,
  output logic                    busy,
  output logic                    done,
  output logic [1:0]              op_kind,
  output logic [$clog2(NREG)-1:0] op_idx,
  output logic [DW-1:0]           op_addr,
  output logic [DW-1:0]           op_value,
  output logic [DW-1:0]           sp_out,
  output logic [DW-1:0]           pc_out,
  output logic [1:0]              extra_cycles,
  output logic                    wr_en
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] EXT_COST = 2'd1;

  opk_e          c_kind;
  logic [IW-1:0] c_idx;
  logic          c_ext, c_extval;
  logic [DW-1:0] c_base, c_value, c_sp;
  logic          go, fire;

  opr_classify #(.DW(DW), .NREG(NREG), .SW(SW)) u_cls (
    .sel(sel), .is_a(is_a), .regs(regs), .sp_in(sp_in), .pc_in(pc_in),
    .ex_in(ex_in), .kind(c_kind), .idx(c_idx), .need_ext(c_ext),
    .ext_is_val(c_extval), .base(c_base), .value(c_value), .sp_new(c_sp)
  );

  assign go = start & ~ext_valid;

  opr_extfetch #(.AW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .launch(go & c_ext), .pc_in(pc_in),
    .ext_ready(ext_ready), .ext_valid(ext_valid), .ext_addr(ext_addr),
    .fire(fire)
  );

  assign busy = ext_valid;

  // pending operand while the extension word is outstanding
  opk_e          p_kind;
  logic [IW-1:0] p_idx;
  logic          p_extval;
  logic [DW-1:0] p_base, p_sp, p_pc;
  logic          p_en;

  assign p_en = go & c_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_kind   <= OK_REG;
      p_idx    <= '0;
      p_extval <= 1'b0;
      p_base   <= '0;
      p_sp     <= '0;
      p_pc     <= '0;
    end else if (p_en) begin
      p_kind   <= c_kind;
      p_idx    <= c_idx;
      p_extval <= c_extval;
      p_base   <= c_base;
      p_sp     <= c_sp;
      p_pc     <= pc_in + DW'(1);
    end
  end

  // result registers
  opk_e          r_kind_q, r_kind_d;
  logic [IW-1:0] r_idx_q, r_idx_d;
  logic [DW-1:0] r_addr_q, r_addr_d, r_val_q, r_val_d;
  logic [DW-1:0] r_sp_q, r_sp_d, r_pc_q, r_pc_d;
  logic [1:0]    r_xc_q, r_xc_d;
  logic          r_wr_q, r_wr_d, done_q, r_en;

  always_comb begin
    r_en = (go & ~c_ext) | fire;
    if (fire) begin
      r_kind_d = p_kind;
      r_idx_d  = p_idx;
      r_addr_d = p_extval ? '0 : p_base + ext_data;
      r_val_d  = p_extval ? ext_data : '0;
      r_sp_d   = p_sp;
      r_pc_d   = p_pc;
      r_xc_d   = EXT_COST;
    end else begin
      r_kind_d = c_kind;
      r_idx_d  = c_idx;
      r_addr_d = c_base;
      r_val_d  = c_value;
      r_sp_d   = c_sp;
      r_pc_d   = pc_in;
      r_xc_d   = 2'd0;
    end
    r_wr_d = (r_kind_d != OK_LIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      r_kind_q <= OK_REG;
      r_idx_q  <= '0;
      r_addr_q <= '0;
      r_val_q  <= '0;
      r_sp_q   <= '0;
      r_pc_q   <= '0;
      r_xc_q   <= '0;
      r_wr_q   <= 1'b0;
    end else begin
      done_q <= r_en;
      if (r_en) begin
        r_kind_q <= r_kind_d;
        r_idx_q  <= r_idx_d;
        r_addr_q <= r_addr_d;
        r_val_q  <= r_val_d;
        r_sp_q   <= r_sp_d;
        r_pc_q   <= r_pc_d;
        r_xc_q   <= r_xc_d;
        r_wr_q   <= r_wr_d;
      end
    end
  end

  assign done         = done_q;
  assign op_kind      = r_kind_q;
  assign op_idx       = r_idx_q;
  assign op_addr      = r_addr_q;
  assign op_value     = r_val_q;
  assign sp_out       = r_sp_q;
  assign pc_out       = r_pc_q;
  assign extra_cycles = r_xc_q;
  assign wr_en        = r_wr_q;

endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          ext_valid,
  input logic          ext_ready,
  input logic [DW-1:0] ext_addr,
  input logic          done,
  input logic [1:0]    op_kind,
  input logic [DW-1:0] op_addr,
  input logic [1:0]    extra_cycles,
  input logic          wr_en
);

  // R10: request and results hold while the word is outstanding
  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) && $stable(op_addr) && !done));

  // R10: result follows the delivery cycle
  assert_fetch_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_valid && ext_ready) |=> (done && !ext_valid));

  // R8: literal operands are never writable
  assert_lit_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_kind == 2'd3) |-> !wr_en);

  // R1: non-literal operands stay writable
  assert_loc_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_kind != 2'd3) |-> wr_en);

  // R11: an accepted request either completes or starts a fetch
  assert_quick_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (done || ext_valid));

  // R12: a request during a pending fetch yields nothing
  assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ext_ready) |=> !done);

  // R3: extra cost appears exactly on fetched operands
  assert_extra_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((extra_cycles != 2'd0) == $past(ext_valid)));

endmodule

bind opnd_resolver opnd_resolver_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_addr(ext_addr),
  .done(done), .op_kind(op_kind), .op_addr(op_addr),
  .extra_cycles(extra_cycles), .wr_en(wr_en)
);

// File: tb/opnd_resolver_test.sv
module opnd_resolver_test;
  localparam int DW = 16;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] sel = '0;
  logic is_a = 1'b1;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0] sp_i = 16'h8000, pc_i = 16'h0040, ex_i = 16'hBEEF;
  logic ext_valid, ext_ready = 1'b0, busy, done, wr_en;
  logic [DW-1:0] ext_addr, ext_data = '0, op_addr, op_value, sp_out, pc_out;
  logic [1:0] op_kind, extra_cycles;
  logic [2:0] op_idx;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opnd_resolver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .is_a(is_a),
    .regs(regs), .sp_in(sp_i), .pc_in(pc_i), .ex_in(ex_i),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_ready(ext_ready),
    .ext_data(ext_data), .busy(busy), .done(done), .op_kind(op_kind),
    .op_idx(op_idx), .op_addr(op_addr), .op_value(op_value),
    .sp_out(sp_out), .pc_out(pc_out), .extra_cycles(extra_cycles),
    .wr_en(wr_en)
  );

  function automatic logic [DW-1:0] rv(int i);
    return 16'(16'h1000 + i * 16'h0111);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic res(input string tag, input logic [1:0] k, input logic [2:0] ix,
                     input logic [15:0] ad, input logic [15:0] v,
                     input logic [15:0] sp, input logic [15:0] pc,
                     input logic [1:0] xc, input logic w);
    chk({tag, " done"}, done, 1);
    chk({tag, " kind"}, op_kind, k);
    chk({tag, " idx"}, op_idx, ix);
    chk({tag, " addr"}, op_addr, ad);
    chk({tag, " value"}, op_value, v);
    chk({tag, " sp"}, sp_out, sp);
    chk({tag, " pc"}, pc_out, pc);
    chk({tag, " extra"}, extra_cycles, xc);
    chk({tag, " wr"}, wr_en, w);
  endtask

  task automatic issue(input logic [5:0] s, input logic a);
    @(negedge clk);
    sel = s; is_a = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fetch(input string tag, input logic [15:0] word, input int waits);
    chk({tag, " R10 ext_valid"}, ext_valid, 1);
    chk({tag, " R10 ext_addr"}, ext_addr, pc_i);
    chk({tag, " R10 busy"}, busy, 1);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk({tag, " R10 hold valid"}, ext_valid, 1);
      chk({tag, " R10 hold addr"}, ext_addr, pc_i);
      chk({tag, " R10 no done"}, done, 0);
    end
    ext_ready = 1'b1; ext_data = word;
    @(negedge clk);
    ext_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("reset done", done, 0);
    chk("reset ext_valid", ext_valid, 0);
    chk("reset busy", busy, 0);
    chk("reset kind", op_kind, 0);
  endtask

  task automatic t_regs;
    for (int i = 0; i < 8; i++) begin
      issue(6'(i), 1'b1);
      res("R1 R11 reg", 2'd0, 3'(i), 16'h0, rv(i), sp_i, pc_i, 2'd0, 1'b1);
    end
    @(negedge clk);
    chk("R11 done pulse", done, 0);
  endtask

  task automatic t_memreg;
    issue(6'h0b, 1'b1);
    res("R2 [X]", 2'd1, 3'd3, rv(3), 16'h0, sp_i, pc_i, 2'd0, 1'b1);
    issue(6'h0f, 1'b0);
    res("R2 [J] b", 2'd1, 3'd7, rv(7), 16'h0, sp_i, pc_i, 2'd0, 1'b1);
  endtask

  task automatic t_memoff;
    issue(6'h12, 1'b1);
    fetch("R3 off", 16'h0010, 2);
    res("R3 [C+w]", 2'd1, 3'd2, rv(2) + 16'h0010, 16'h0, sp_i, pc_i + 16'd1, 2'd1, 1'b1);
    issue(6'h14, 1'b0);
    fetch("R3 wrap", 16'hF000, 0);
    res("R3 [Y+w] wrap", 2'd1, 3'd4, rv(4) + 16'hF000, 16'h0, sp_i, pc_i + 16'd1, 2'd1, 1'b1);
  endtask

  task automatic t_stack;
    issue(6'h18, 1'b0);
    res("R4 push", 2'd1, 3'd0, sp_i - 16'd1, 16'h0, sp_i - 16'd1, pc_i, 2'd0, 1'b1);
    issue(6'h18, 1'b1);
    res("R4 pop", 2'd1, 3'd0, sp_i, 16'h0, sp_i + 16'd1, pc_i, 2'd0, 1'b1);
    sp_i = 16'h0000;
    issue(6'h18, 1'b0);
    res("R4 push wrap", 2'd1, 3'd0, 16'hFFFF, 16'h0, 16'hFFFF, pc_i, 2'd0, 1'b1);
    sp_i = 16'hFFFF;
    issue(6'h18, 1'b1);
    res("R4 pop wrap", 2'd1, 3'd0, 16'hFFFF, 16'h0, 16'h0000, pc_i, 2'd0, 1'b1);
    sp_i = 16'h8000;
  endtask

  task automatic t_peekpick;
    issue(6'h19, 1'b1);
    res("R5 peek", 2'd1, 3'd0, sp_i, 16'h0, sp_i, pc_i, 2'd0, 1'b1);
    issue(6'h1a, 1'b0);
    fetch("R5 pick", 16'h0003, 1);
    res("R5 pick", 2'd1, 3'd0, sp_i + 16'd3, 16'h0, sp_i, pc_i + 16'd1, 2'd1, 1'b1);
  endtask

  task automatic t_special;
    issue(6'h1b, 1'b1);
    res("R6 SP", 2'd2, 3'd0, 16'h0, sp_i, sp_i, pc_i, 2'd0, 1'b1);
    issue(6'h1c, 1'b0);
    res("R6 PC", 2'd2, 3'd1, 16'h0, pc_i, sp_i, pc_i, 2'd0, 1'b1);
    issue(6'h1d, 1'b1);
    res("R6 EX", 2'd2, 3'd2, 16'h0, ex_i, sp_i, pc_i, 2'd0, 1'b1);
  endtask

  task automatic t_nextword;
    issue(6'h1e, 1'b1);
    fetch("R7 abs", 16'h2345, 0);
    res("R7 [w]", 2'd1, 3'd0, 16'h2345, 16'h0, sp_i, pc_i + 16'd1, 2'd1, 1'b1);
    issue(6'h1f, 1'b1);
    fetch("R7 imm", 16'hCAFE, 3);
    res("R7 imm", 2'd3, 3'd0, 16'h0, 16'hCAFE, sp_i, pc_i + 16'd1, 2'd1, 1'b0);
  endtask

  task automatic t_lits;
    issue(6'h20, 1'b1);
    res("R8 lit -1", 2'd3, 3'd0, 16'h0, 16'hFFFF, sp_i, pc_i, 2'd0, 1'b0);
    issue(6'h21, 1'b1);
    res("R8 lit 0", 2'd3, 3'd0, 16'h0, 16'h0000, sp_i, pc_i, 2'd0, 1'b0);
    issue(6'h3f, 1'b1);
    res("R8 lit 30", 2'd3, 3'd0, 16'h0, 16'd30, sp_i, pc_i, 2'd0, 1'b0);
  endtask

  task automatic t_bfield;
    issue(6'h21, 1'b0);
    res("R9 b 0x21->B", 2'd0, 3'd1, 16'h0, rv(1), sp_i, pc_i, 2'd0, 1'b1);
    issue(6'h38, 1'b0);
    res("R9 b 0x38->push", 2'd1, 3'd0, sp_i - 16'd1, 16'h0, sp_i - 16'd1, pc_i, 2'd0, 1'b1);
  endtask

  task automatic t_busy;
    issue(6'h1e, 1'b1);
    sel = 6'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 no done while busy", done, 0);
    chk("R12 still fetching", ext_valid, 1);
    fetch("R12 abs", 16'h4321, 0);
    res("R12 first result", 2'd1, 3'd0, 16'h4321, 16'h0, sp_i, pc_i + 16'd1, 2'd1, 1'b1);
    @(negedge clk);
    chk("R12 no second result", done, 0);
    chk("R12 kind kept", op_kind, 2'd1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) regs[i*DW +: DW] = rv(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_regs();
    t_memreg();
    t_memoff();
    t_stack();
    t_peekpick();
    t_special();
    t_nextword();
    t_lits();
    t_bfield();
    t_busy();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule